// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block converts a 32-bit linear address into a physical address. It walks a two-level translation structure whose root is a directory base supplied by software. A requester hands over a linear address, a write flag and its current privilege level. The walker then reads one directory entry and one table entry through a read port that has a request channel and a response channel, each with a valid/ready handshake and any latency. Only one read is in flight at a time.

The walker returns either the physical address or a page fault with a reason code. The result is held on the result channel until the requester takes it. Either entry can block access. A clear present bit at either level does so. For a user-level requester, a missing user bit or, on a write, a missing writable bit at either level also blocks access.

The controller is a state machine with five named states:
- `ST_IDLE`: accepts a request.
- `ST_FETCH_DIR`: issues the directory read, then waits for its response.
- `ST_FETCH_PTE`: issues the table read, then waits for its response.
- `ST_DONE` and `ST_FAULT`: present the result.

The transitions are:
- IDLE→FETCH_DIR on an accepted request.
- FETCH_DIR→FETCH_PTE on a present directory entry.
- FETCH_DIR→FAULT on an absent directory entry.
- FETCH_PTE→DONE when the table entry passes every check.
- FETCH_PTE→FAULT when it fails any check.
- DONE/FAULT→IDLE when the result is accepted.

Top module: `pgwalk_top`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, `mem_req_valid` is 0 and `res_valid` is 0.
- R2: The first read goes to address {root_base[31:12], 12'h000} + 4 × laddr[31:22]. The root value used is the one present when the request is accepted.
- R3: The second read goes to address {dir_entry[31:12], 12'h000} + 4 × laddr[21:12].
- R4: On success, `res_fault` is 0, `res_reason` is 0 and `res_paddr` = {table_entry[31:12], laddr[11:0]}. Entry bit 0 is present, bit 1 is writable and bit 2 is user.
- R5: If directory bit 0 is clear, the result is a fault with reason 1, no second read is issued and `res_paddr` is 0.
- R6: If table entry bit 0 is clear, the result is a fault with reason 2.
- R7: A requester at level 3 gets a fault with reason 3 unless bit 2 is set in both entries. Levels 0, 1 and 2 are not checked against bit 2.
- R8: A write at level 3 gets a fault with reason 4 unless bit 1 is set in both entries. Writes at levels 0 to 2 are not checked against bit 1.
- R9: At most one read is outstanding. `mem_req_valid` and `mem_req_addr` hold steady until the read is accepted, and no new read is issued in the cycle after an acceptance.
- R10: `req_ready` is 0 from acceptance until the result is taken. A presented result keeps its valid, fault and reason values until `res_ready` is 1.
- R11: When several fault conditions apply, the lowest reason code wins, in the order directory absent, table absent, user denied, write denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| root_base | input | 32 | Directory base; bits 31:12 are used |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker can accept a request |
| req_laddr | input | 32 | Linear address to translate |
| req_write | input | 1 | Access is a write |
| req_cpl | input | 2 | Requester privilege level (3 = user) |
| mem_req_valid | output | 1 | Entry read request present |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_ready | output | 1 | Walker can take read data |
| mem_rsp_data | input | 32 | Entry contents |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Requester takes the result |
| res_paddr | output | 32 | Physical address (0 on fault) |
| res_fault | output | 1 | Result is a page fault |
| res_reason | output | 3 | 0 none, 1 directory absent, 2 table absent, 3 user denied, 4 write denied |

## Verification
The hardest conditions to reach from the ports are the fault-precedence cases. In these, two or three fault conditions hold together, for example a user write through a directory entry without the user bit that points at an absent table entry. A fixed memory image is built with one directory or table slot for each flag combination. The image also has entries at index 0 and index 1023, and a second root so that a change of `root_base` is observed. Memory latency on both channels varies from walk to walk, and the result channel is stalled on every third presentation. As a result, requests arrive while a result is still held and reads sit unaccepted for several cycles.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

    localparam int ENT_W   = 32;
    localparam int BIT_P   = 0;
    localparam int BIT_W   = 1;
    localparam int BIT_U   = 2;
    localparam int FLAGS_W = 3;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_FETCH_DIR = 3'd1,
        ST_FETCH_PTE = 3'd2,
        ST_DONE      = 3'd3,
        ST_FAULT     = 3'd4
    } walk_state_e;

    typedef enum logic [2:0] {
        FLT_NONE       = 3'd0,
        FLT_DIR_ABSENT = 3'd1,
        FLT_TBL_ABSENT = 3'd2,
        FLT_USER       = 3'd3,
        FLT_WRITE      = 3'd4
    } fault_code_e;

endpackage

// File: rtl/pgwalk_addr.sv
module pgwalk_addr #(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 12,
    parameter int IDX_W  = 10
) (
    input  logic [ADDR_W-OFS_W-1:0] base_frame,
    input  logic [IDX_W-1:0]        index,
    output logic [ADDR_W-1:0]       entry_addr
);
    localparam int FRAME_W = ADDR_W - OFS_W;

    logic [ADDR_W-1:0] base_bytes;
    logic [ADDR_W-1:0] ofs_bytes;

    assign base_bytes = {base_frame, {OFS_W{1'b0}}};
    assign ofs_bytes  = {{(ADDR_W-IDX_W-2){1'b0}}, index, 2'b00};
    assign entry_addr = base_bytes + ofs_bytes;

    initial begin
        if (FRAME_W + OFS_W != ADDR_W) $display("pgwalk_addr: width mismatch");
    end
endmodule

// File: rtl/pgwalk_perm.sv
module pgwalk_perm
    import pgwalk_pkg::*;
(
    input  logic [FLAGS_W-1:0] dir_flags,
    input  logic [FLAGS_W-1:0] tbl_flags,
    input  logic               is_user,
    input  logic               is_write,
    output logic               deny,
    output fault_code_e        cause
);
    logic user_ok;
    logic write_ok;

    assign user_ok  = dir_flags[BIT_U] & tbl_flags[BIT_U];
    assign write_ok = dir_flags[BIT_W] & tbl_flags[BIT_W];

    always_comb begin
        deny  = 1'b0;
        cause = FLT_NONE;
        if (!tbl_flags[BIT_P]) begin
            deny  = 1'b1;
            cause = FLT_TBL_ABSENT;
        end else if (is_user && !user_ok) begin
            deny  = 1'b1;
            cause = FLT_USER;
        end else if (is_user && is_write && !write_ok) begin
            deny  = 1'b1;
            cause = FLT_WRITE;
        end
    end
endmodule

// File: rtl/pgwalk_fsm.sv
module pgwalk_fsm
    import pgwalk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [ADDR_W-1:0]       dir_addr,
    input  logic [ADDR_W-1:0]       pte_addr,
    output logic                    mem_req_valid,
    input  logic                    mem_req_ready,
    output logic [ADDR_W-1:0]       mem_req_addr,
    input  logic                    mem_rsp_valid,
    output logic                    mem_rsp_ready,
    input  logic [ADDR_W-OFS_W-1:0] rsp_frame,
    input  logic [FLAGS_W-1:0]      rsp_flags,
    input  logic                    perm_deny,
    input  fault_code_e             perm_cause,
    output logic [ADDR_W-OFS_W-1:0] dir_frame_q,
    output logic [FLAGS_W-1:0]      dir_flags_q,
    output logic [ADDR_W-OFS_W-1:0] tbl_frame_q,
    input  logic                    res_ready,
    output logic                    res_valid,
    output logic                    res_fault,
    output fault_code_e             res_reason
);
    localparam int FRAME_W = ADDR_W - OFS_W;

    walk_state_e st_q, st_d;
    logic        issued_q, issued_d;
    fault_code_e cause_q, cause_d;
    logic        fetching;
    logic        rsp_fire;

    assign fetching = (st_q == ST_FETCH_DIR) || (st_q == ST_FETCH_PTE);
    assign rsp_fire = fetching && issued_q && mem_rsp_valid;

    // next-state and walk bookkeeping
    always_comb begin
        st_d     = st_q;
        issued_d = issued_q;
        cause_d  = cause_q;
        unique case (st_q)
            ST_IDLE: begin
                if (req_valid) begin
                    st_d    = ST_FETCH_DIR;
                    cause_d = FLT_NONE;
                end
            end
            ST_FETCH_DIR: begin
                if (!issued_q && mem_req_ready) issued_d = 1'b1;
                if (rsp_fire) begin
                    issued_d = 1'b0;
                    if (!rsp_flags[BIT_P]) begin
                        st_d    = ST_FAULT;
                        cause_d = FLT_DIR_ABSENT;
                    end else begin
                        st_d = ST_FETCH_PTE;
                    end
                end
            end
            ST_FETCH_PTE: begin
                if (!issued_q && mem_req_ready) issued_d = 1'b1;
                if (rsp_fire) begin
                    issued_d = 1'b0;
                    if (perm_deny) begin
                        st_d    = ST_FAULT;
                        cause_d = perm_cause;
                    end else begin
                        st_d = ST_DONE;
                    end
                end
            end
            ST_DONE, ST_FAULT: begin
                if (res_ready) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= ST_IDLE;
            issued_q    <= 1'b0;
            cause_q     <= FLT_NONE;
            dir_frame_q <= '0;
            dir_flags_q <= '0;
            tbl_frame_q <= '0;
        end else begin
            st_q     <= st_d;
            issued_q <= issued_d;
            cause_q  <= cause_d;
            if (rsp_fire && st_q == ST_FETCH_DIR) begin
                dir_frame_q <= rsp_frame;
                dir_flags_q <= rsp_flags;
            end
            if (rsp_fire && st_q == ST_FETCH_PTE) begin
                tbl_frame_q <= rsp_frame;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready     = (st_q == ST_IDLE);
        mem_req_valid = fetching && !issued_q;
        mem_rsp_ready = fetching && issued_q;
        mem_req_addr  = (st_q == ST_FETCH_PTE) ? pte_addr : dir_addr;
        res_valid     = (st_q == ST_DONE) || (st_q == ST_FAULT);
        res_fault     = (st_q == ST_FAULT);
        res_reason    = (st_q == ST_FAULT) ? cause_q : FLT_NONE;
    end

    AST_MEMREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R9
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_ready |=> !mem_req_valid); // R9
    AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !res_ready |=> res_valid && $stable(res_fault) && $stable(res_reason)); // R10
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready && mem_req_valid); // R10
    AST_DIR_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FETCH_DIR) && mem_rsp_valid && mem_rsp_ready && !rsp_flags[BIT_P]
        |=> res_valid && res_fault && (res_reason == FLT_DIR_ABSENT)); // R5
    AST_FAULT_CODED: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_fault |-> res_reason != FLT_NONE); // R11

    initial begin
        if (FRAME_W <= 0) $display("pgwalk_fsm: bad widths");
    end
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
    import pgwalk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 10,
    parameter int OFS_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] root_base,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_laddr,
    input  logic              req_write,
    input  logic [1:0]        req_cpl,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    output logic              mem_rsp_ready,
    input  logic [ADDR_W-1:0] mem_rsp_data,
    output logic              res_valid,
    input  logic              res_ready,
    output logic [ADDR_W-1:0] res_paddr,
    output logic              res_fault,
    output logic [2:0]        res_reason
);
    localparam int FRAME_W = ADDR_W - OFS_W;
    localparam int DIR_LO  = OFS_W + IDX_W;
    localparam int TBL_LO  = OFS_W;

    logic [ADDR_W-1:0]  laddr_q;
    logic               write_q;
    logic               user_q;
    logic [FRAME_W-1:0] root_q;

    logic [ADDR_W-1:0]  dir_addr, pte_addr;
    logic [FRAME_W-1:0] dir_frame_q, tbl_frame_q;
    logic [FLAGS_W-1:0] dir_flags_q;
    logic               perm_deny;
    fault_code_e        perm_cause;
    fault_code_e        reason_e;
    logic               unused_rsp_bits;

    assign unused_rsp_bits = ^mem_rsp_data[OFS_W-1:FLAGS_W];

    // request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            laddr_q <= '0;
            write_q <= 1'b0;
            user_q  <= 1'b0;
            root_q  <= '0;
        end else if (req_valid && req_ready) begin
            laddr_q <= req_laddr;
            write_q <= req_write;
            user_q  <= (req_cpl == 2'd3);
            root_q  <= root_base[ADDR_W-1:OFS_W];
        end
    end

    pgwalk_addr #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .IDX_W(IDX_W)) u_dir_addr (
        .base_frame (root_q),
        .index      (laddr_q[DIR_LO+IDX_W-1:DIR_LO]),
        .entry_addr (dir_addr)
    );

    pgwalk_addr #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .IDX_W(IDX_W)) u_pte_addr (
        .base_frame (dir_frame_q),
        .index      (laddr_q[TBL_LO+IDX_W-1:TBL_LO]),
        .entry_addr (pte_addr)
    );

    pgwalk_perm u_perm (
        .dir_flags (dir_flags_q),
        .tbl_flags (mem_rsp_data[FLAGS_W-1:0]),
        .is_user   (user_q),
        .is_write  (write_q),
        .deny      (perm_deny),
        .cause     (perm_cause)
    );

    pgwalk_fsm #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .dir_addr      (dir_addr),
        .pte_addr      (pte_addr),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_ready (mem_rsp_ready),
        .rsp_frame     (mem_rsp_data[ADDR_W-1:OFS_W]),
        .rsp_flags     (mem_rsp_data[FLAGS_W-1:0]),
        .perm_deny     (perm_deny),
        .perm_cause    (perm_cause),
        .dir_frame_q   (dir_frame_q),
        .dir_flags_q   (dir_flags_q),
        .tbl_frame_q   (tbl_frame_q),
        .res_ready     (res_ready),
        .res_valid     (res_valid),
        .res_fault     (res_fault),
        .res_reason    (reason_e)
    );

    assign res_reason = reason_e;
    assign res_paddr  = (res_valid && !res_fault) ? {tbl_frame_q, laddr_q[OFS_W-1:0]} : '0;

    AST_PADDR_ZERO_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_fault |-> res_paddr == '0); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req_valid && !res_valid); // R1
endmodule

// File: tb/pgwalk_top_tb.sv
module pgwalk_top_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] root_base;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_laddr;
    logic        req_write;
    logic [1:0]  req_cpl;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic        mem_rsp_ready;
    logic [31:0] mem_rsp_data;
    logic        res_valid;
    logic        res_ready;
    logic [31:0] res_paddr;
    logic        res_fault;
    logic [2:0]  res_reason;

    always #2 clk = ~clk;

    pgwalk_top u_dut (
        .clk(clk), .rst_n(rst_n), .root_base(root_base),
        .req_valid(req_valid), .req_ready(req_ready), .req_laddr(req_laddr),
        .req_write(req_write), .req_cpl(req_cpl),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
        .res_valid(res_valid), .res_ready(res_ready), .res_paddr(res_paddr),
        .res_fault(res_fault), .res_reason(res_reason)
    );

    typedef struct {
        logic [31:0] paddr;
        logic        fault;
        logic [2:0]  reason;
        int          fetches;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    logic [31:0] mem [int unsigned];
    int          vectors = 0;
    int          miscompares = 0;
    int          fetch_cnt = 0;
    int          fetch_seen = 0;
    int unsigned seed = 32'h1234_5678;
    int          cycles = 0;
    bit          done = 0;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    function automatic logic [31:0] mk(input int d, input int t, input int o);
        return {d[9:0], t[9:0], o[11:0]};
    endfunction

    function automatic int unsigned nxt();
        seed = seed * 32'd1103515245 + 32'd12345;
        return (seed >> 16) & 3;
    endfunction

    // expected result built from R2..R8 and R11
    task automatic walk(input logic [31:0] la, input bit wr, input logic [1:0] cpl, input string tag);
        exp_t e;
        logic [31:0] de, te;
        bit user;
        user = (cpl == 2'd3);
        de = rd({root_base[31:12], 12'h000} + {20'h0, la[31:22], 2'b00});
        e.tag = tag; e.paddr = 32'h0; e.fault = 1'b1;
        if (!de[0]) begin
            e.reason = 3'd1; e.fetches = 1;
        end else begin
            te = rd({de[31:12], 12'h000} + {20'h0, la[21:12], 2'b00});
            e.fetches = 2;
            if (!te[0]) e.reason = 3'd2;
            else if (user && !(de[2] && te[2])) e.reason = 3'd3;
            else if (user && wr && !(de[1] && te[1])) e.reason = 3'd4;
            else begin
                e.reason = 3'd0; e.fault = 1'b0; e.paddr = {te[31:12], la[11:0]};
            end
        end
        sb_q.push_back(e);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_laddr = la; req_write = wr; req_cpl = cpl;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (sb_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // memory model: variable latency on both channels
    initial begin
        logic [31:0] a;
        mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = 32'h0;
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if (mem_req_valid) begin
                repeat (nxt()) @(negedge clk);
                a = mem_req_addr;
                mem_req_ready = 1'b1;
                @(negedge clk);
                mem_req_ready = 1'b0;
                fetch_cnt++;
                repeat (nxt()) @(negedge clk);
                mem_rsp_valid = 1'b1; mem_rsp_data = rd(a);
                @(negedge clk);
                mem_rsp_valid = 1'b0; mem_rsp_data = 32'hDEAD_BEEF;
            end
        end
    end

    // monitor / scoreboard
    initial begin
        int phase = 0;
        bit hold = 0;
        logic [31:0] h_pa;
        logic h_f;
        logic [2:0] h_r;
        exp_t e;
        res_ready = 1'b0;
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if (hold) begin
                chk("R10", "held valid", {31'h0, res_valid}, 32'h1);
                chk("R10", "held result", {h_pa[28:0], h_f, h_r[1:0]} ^ {res_paddr[28:0], res_fault, res_reason[1:0]}, 32'h0);
            end
            res_ready = 1'b0;
            hold = 0;
            if (res_valid) begin
                phase++;
                if (phase % 3 == 0) begin
                    hold = 1; h_pa = res_paddr; h_f = res_fault; h_r = res_reason;
                end else begin
                    res_ready = 1'b1;
                    if (sb_q.size() == 0) begin
                        miscompares++;
                        $display("FAIL R10 unexpected result: actual %h expected none", res_paddr);
                    end else begin
                        e = sb_q.pop_front();
                        chk(e.tag, "fault", {31'h0, res_fault}, {31'h0, e.fault});
                        chk(e.tag, "reason", {29'h0, res_reason}, {29'h0, e.reason});
                        chk(e.tag, "paddr", res_paddr, e.paddr);
                        chk(e.tag, "reads", fetch_cnt - fetch_seen, e.fetches);
                        fetch_seen = fetch_cnt;
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles == 50000 && !done) begin
                miscompares++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
                $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
                $finish;
            end
        end
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_laddr = 32'h0; req_write = 1'b0; req_cpl = 2'd0;
        root_base = 32'h0010_0000;
        // root A directory: entry flags bit0 present, bit1 writable, bit2 user
        mem[32'h0010_0000 + 4*1]     = 32'h0020_0007;
        mem[32'h0010_0000 + 4*2]     = 32'h0021_0003;
        mem[32'h0010_0000 + 4*3]     = 32'h0022_0005;
        mem[32'h0010_0000 + 4*4]     = 32'h0023_0006;
        mem[32'h0010_0000 + 4*1023]  = 32'h0024_0007;
        mem[32'h0010_0000 + 4*0]     = 32'h0025_0007;
        mem[32'h0020_0000 + 4*5]     = 32'hABCD_E007;
        mem[32'h0020_0000 + 4*6]     = 32'h1234_5003;
        mem[32'h0020_0000 + 4*7]     = 32'h5555_5005;
        mem[32'h0020_0000 + 4*8]     = 32'h7777_7006;
        mem[32'h0020_0000 + 4*9]     = 32'h0000_1001;
        mem[32'h0021_0000 + 4*5]     = 32'h1111_1007;
        mem[32'h0022_0000 + 4*5]     = 32'h2222_2007;
        mem[32'h0024_0000 + 4*1023]  = 32'hFEDC_B007;
        mem[32'h0025_0000 + 4*0]     = 32'h0ABC_0007;
        // root B
        mem[32'h0030_0000 + 4*1]     = 32'h0031_0007;
        mem[32'h0031_0000 + 4*5]     = 32'h9999_9007;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "req_ready", {31'h0, req_ready}, 32'h1);
        chk("R1", "mem_req_valid", {31'h0, mem_req_valid}, 32'h0);
        chk("R1", "res_valid", {31'h0, res_valid}, 32'h0);

        walk(mk(1, 5, 12'h123), 0, 2'd0, "R4 sup read");
        walk(mk(1, 5, 12'hFFF), 1, 2'd3, "R8 user write allowed");
        walk(mk(2, 5, 12'h010), 0, 2'd3, "R7 dir user clear");
        walk(mk(1, 6, 12'h010), 0, 2'd3, "R7 table user clear");
        walk(mk(2, 5, 12'h010), 1, 2'd0, "R7 sup ignores user bit");
        walk(mk(1, 7, 12'h020), 1, 2'd3, "R8 table not writable");
        walk(mk(3, 5, 12'h030), 1, 2'd3, "R8 dir not writable");
        walk(mk(1, 7, 12'h040), 1, 2'd0, "R8 sup write ignores writable");
        walk(mk(1, 7, 12'h040), 0, 2'd3, "R8 user read of read-only");
        walk(mk(4, 5, 12'h000), 0, 2'd0, "R5 dir absent");
        walk(mk(4, 5, 12'h000), 1, 2'd3, "R11 dir absent first");
        walk(mk(1, 8, 12'h000), 0, 2'd0, "R6 table absent");
        walk(mk(2, 8, 12'h000), 1, 2'd3, "R11 table absent before user");
        walk(mk(1, 9, 12'h000), 1, 2'd3, "R11 user before write");
        walk(mk(1023, 1023, 12'hFFF), 0, 2'd3, "R3 top indices");
        walk(mk(0, 0, 12'h000), 0, 2'd0, "R3 zero indices");
        walk(mk(1, 6, 12'h010), 0, 2'd1, "R7 level 1 is supervisor");
        drain();

        root_base = 32'h0030_0000;
        walk(mk(1, 5, 12'h123), 0, 2'd0, "R2 new root");
        walk(mk(2, 5, 12'h000), 0, 2'd0, "R2 R5 unmapped under new root");
        drain();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule